// File: doc/BRIEF.md
# Store/Busy Pin Handshake Controller

This controller sits between a bidirectional, open-drain, active-low store/busy pin and the access path of a nonvolatile-backed SRAM. An outside agent asks for a store by pulling the pin low. The controller synchronizes the pin and filters out glitches. It lets accesses in flight run out during a grace window, then asks the nonvolatile engine to copy the array, but only when the array has been written since the last transfer. While the copy runs, the controller pulls the pin low itself, so the pin also serves as a busy flag to the outside world.

Once the engine reports completion, the controller releases the pin. It keeps the array closed until it sees the pin high again and a recovery time has passed. Read and write requests come in on one request/strobe pair and are granted through two qualifying outputs. The grace, recovery and glitch-filter lengths are cycle-count parameters. The copy itself is done elsewhere.

Top module: `nvstore_pin_ctrl`

## Requirements
- R1: After reset the pin driver is released (`pin_drive_low`=0), `store_start` is 0 and an access request is granted.
- R2: A low level on the synchronized pin that lasts fewer than MIN_PULSE consecutive cycles starts nothing, and writes are granted again afterwards. A low level of MIN_PULSE or more cycles is accepted as a store request.
- R3: If `dirty` is 1 at the end of the grace window, `store_start` pulses high for exactly one cycle. The pulse is observed SYNC_STAGES+MIN_PULSE+GRACE_CYC+1 clock edges after the edge at which `pin_in` is first sampled low.
- R4: If `dirty` is 0 at the end of the grace window, no `store_start` occurs and the pin is never driven low.
- R5: A read request (`acc_req`=1, `acc_wr`=0) is granted on `rd_ok` during the grace window.
- R6: A write request (`acc_req`=1, `acc_wr`=1) that was granted before the pin went low and is held continuously keeps `wr_ok` until the grace window ends.
- R7: A write request that starts after the synchronized pin is low is refused. When no store ran, a write is granted again SYNC_STAGES+1 edges after the pin is released.
- R8: `pin_drive_low` rises in the same cycle as `store_start` and never before it. It stays high until `store_done` is sampled, and it is 0 in the next cycle.
- R9: From the store start until recovery, neither `rd_ok` nor `wr_ok` is granted, even while the pin is held low. Grants return SYNC_STAGES+1+RECOVER_CYC edges after the pin is seen high.
- R10: `store_done` has no effect while no store is running. This holds both when idle and during the grace window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Raw sample of the store/busy pin (low = request or busy) |
| pin_drive_low | output | 1 | Open-drain enable: 1 pulls the pin low |
| acc_req | input | 1 | SRAM access request |
| acc_wr | input | 1 | 1 = request is a write, 0 = read |
| rd_ok | output | 1 | Read request granted this cycle |
| wr_ok | output | 1 | Write request granted this cycle |
| dirty | input | 1 | Array written since the last store or recall |
| store_done | input | 1 | Nonvolatile engine finished the store |
| store_start | output | 1 | One-cycle pulse launching the store |

## Verification
The bench models the wired-AND pin with a pull-up. It aims at pulses one cycle below and exactly at the filter length. A filter that is off by one would either launch a store on a glitch or miss a legal request. It exercises a write held through the request, which a design that blocks all writes at once would cut short. It also exercises a write begun after the pin falls, which a design that keys only on the qualified request would wrongly accept. It measures the exact start and resume latencies, both with the pin released early and with the pin held past completion. A controller that reopened on completion instead of on pin release would grant while the pin is still low. It also pulses completion while idle and during the grace window, which a loose state machine would take as the end of a store.

// File: rtl/nsp_pkg.sv
package nsp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_GRACE = 3'd1,
      ST_STORE = 3'd2,
      ST_HOLD  = 3'd3,
      ST_RECOV = 3'd4,
      ST_SKIP  = 3'd5
   } nsp_state_e;

   function automatic int cnt_width(input int limit);
      return (limit > 1) ? $clog2(limit) : 1;
   endfunction

endpackage

// File: rtl/nsp_sync.sv
module nsp_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 1) begin : g_single
         logic flop;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flop <= RST_VAL;
            else        flop <= d;
         end
         assign q = flop;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[STAGES-2:0], d};
         end
         assign q = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/nsp_pulse_qual.sv
module nsp_pulse_qual #(
   parameter int MIN_PULSE = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   output logic req_q
);

   localparam int QW = $clog2(MIN_PULSE + 1);

   logic [QW-1:0] low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          low_run <= '0;
      else if (pin_s)                      low_run <= '0;
      else if (low_run != QW'(MIN_PULSE))  low_run <= low_run + 1'b1;
   end

   assign req_q = (low_run == QW'(MIN_PULSE));

endmodule

// File: rtl/nsp_tick_cnt.sv
module nsp_tick_cnt #(
   parameter int LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic hit
);

   localparam int CW = nsp_pkg::cnt_width(LIMIT);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (clr)         cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
   end

   assign hit = (cnt == LAST);

endmodule

// File: rtl/nvstore_pin_ctrl.sv
module nvstore_pin_ctrl
   import nsp_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_PULSE   = 4,
   parameter int GRACE_CYC   = 8,
   parameter int RECOVER_CYC = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   output logic pin_drive_low,
   input  logic acc_req,
   input  logic acc_wr,
   output logic rd_ok,
   output logic wr_ok,
   input  logic dirty,
   input  logic store_done,
   output logic store_start
);

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (MIN_PULSE < 1) begin : g_bad_pulse
         $error("MIN_PULSE must be at least 1");
      end
      if (GRACE_CYC < 1) begin : g_bad_grace
         $error("GRACE_CYC must be at least 1");
      end
      if (RECOVER_CYC < 1) begin : g_bad_recov
         $error("RECOVER_CYC must be at least 1");
      end
   endgenerate

   logic       pin_s;
   logic       req_q;
   logic       grace_hit;
   logic       recov_hit;
   logic       start_q;
   logic       wr_hold;
   logic       access_on;
   logic       wr_block;
   nsp_state_e st, nxt;

   nsp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_s)
   );

   nsp_pulse_qual #(.MIN_PULSE(MIN_PULSE)) u_qual (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_s (pin_s),
      .req_q (req_q)
   );

   nsp_tick_cnt #(.LIMIT(GRACE_CYC)) u_grace (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (st != ST_GRACE),
      .hit   (grace_hit)
   );

   nsp_tick_cnt #(.LIMIT(RECOVER_CYC)) u_recov (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (st != ST_RECOV),
      .hit   (recov_hit)
   );

   always_comb begin
      nxt = st;
      unique case (st)
         ST_IDLE:  if (req_q)      nxt = ST_GRACE;
         ST_GRACE: if (grace_hit)  nxt = dirty ? ST_STORE : ST_SKIP;
         ST_STORE: if (store_done) nxt = ST_HOLD;
         ST_HOLD:  if (pin_s)      nxt = ST_RECOV;
         ST_RECOV: if (recov_hit)  nxt = ST_IDLE;
         ST_SKIP:  if (pin_s)      nxt = ST_IDLE;
         default:                  nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         start_q <= 1'b0;
         wr_hold <= 1'b0;
      end else begin
         st      <= nxt;
         start_q <= (st == ST_GRACE) && grace_hit && dirty;
         wr_hold <= wr_ok;
      end
   end

   assign access_on = (st == ST_IDLE) || (st == ST_GRACE) || (st == ST_SKIP);
   assign wr_block  = !pin_s || (st != ST_IDLE);

   assign rd_ok         = acc_req && !acc_wr && access_on;
   assign wr_ok         = acc_req && acc_wr && access_on && (!wr_block || wr_hold);
   assign pin_drive_low = (st == ST_STORE);
   assign store_start   = start_q;

endmodule

// File: rtl/nsp_chk.sv
module nsp_chk (
   input logic clk,
   input logic rst_n,
   input logic pin_sync,
   input logic pin_drive_low,
   input logic store_start,
   input logic store_done,
   input logic dirty,
   input logic rd_ok,
   input logic wr_ok
);

   // R3
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      store_start |=> !store_start);

   // R4
   start_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      store_start |-> $past(dirty));

   // R8
   drive_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pin_drive_low) |-> store_start);

   // R8
   drive_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_drive_low && store_done) |=> !pin_drive_low);

   // R9
   busy_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_drive_low |-> !(rd_ok || wr_ok));

   // R7
   new_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && !$past(wr_ok)) |-> pin_sync);

endmodule

bind nvstore_pin_ctrl nsp_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .pin_sync      (pin_s),
   .pin_drive_low (pin_drive_low),
   .store_start   (store_start),
   .store_done    (store_done),
   .dirty         (dirty),
   .rd_ok         (rd_ok),
   .wr_ok         (wr_ok)
);

// File: tb/sim_nvstore_pin_ctrl.sv
module sim_nvstore_pin_ctrl;

   localparam int S = 2;
   localparam int M = 4;
   localparam int G = 8;
   localparam int R = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ext_low = 1'b0;
   logic acc_req = 1'b0;
   logic acc_wr = 1'b0;
   logic dirty = 1'b0;
   logic store_done = 1'b0;
   logic pin_in, pin_drive_low, rd_ok, wr_ok, store_start;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   assign pin_in = ~(ext_low | pin_drive_low);

   nvstore_pin_ctrl #(.SYNC_STAGES(S), .MIN_PULSE(M), .GRACE_CYC(G), .RECOVER_CYC(R)) u0 (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_drive_low(pin_drive_low),
      .acc_req(acc_req), .acc_wr(acc_wr), .rd_ok(rd_ok), .wr_ok(wr_ok),
      .dirty(dirty), .store_done(store_done), .store_start(store_start)
   );

   function automatic int exp_start_lat();
      return S + M + G + 1;
   endfunction

   function automatic int exp_resume_lat();
      return S + 1 + R;
   endfunction

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         checks++;
         errors++;
         $display("FAIL R3 watchdog actual=%0d expected<%0d", cyc, 100000);
         summary();
      end
   end

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run_store(input bit dty, input bit held, input bit early, input bit spur,
                            input int done_dly, input int hold_dly);
      int  first_start = -1;
      bit  drv_early = 0;
      bit  drv_drop = 0;
      bit  grant_bad = 0;
      int  lat = exp_start_lat();
      int  res = exp_resume_lat();
      dirty = dty;
      store_done = 0;
      acc_req = 1;
      acc_wr = held;
      tick();
      if (held) chk(wr_ok == 1, "R6 write granted before request", wr_ok, 1);
      ext_low = 1;
      for (int n = 1; n <= lat; n++) begin
         tick();
         if (store_start && first_start < 0) first_start = n;
         if (pin_drive_low && n < lat) drv_early = 1;
         if (!held && n == S + M + 1) begin
            chk(rd_ok == 1, "R5 read granted in grace", rd_ok, 1);
            acc_wr = 1;
         end
         if (!held && n == S + M + 2) chk(wr_ok == 0, "R7 new write refused in grace", wr_ok, 0);
         if (held && n == S + M + G) chk(wr_ok == 1, "R6 held write through grace", wr_ok, 1);
         store_done = (spur && n == S + M + 3);
      end
      store_done = 0;
      if (dty) begin
         chk(first_start == lat, "R3 start latency", first_start, lat);
         chk(!drv_early, "R8 no drive before start", drv_early, 0);
         chk(pin_drive_low == 1, "R8 drive with start", pin_drive_low, 1);
         chk(!(rd_ok || wr_ok), "R9 no grant at store start", rd_ok | wr_ok, 0);
         if (early) ext_low = 0;
         for (int k = 1; k <= done_dly; k++) begin
            tick();
            if (k == 1) chk(store_start == 0, "R3 start is one cycle", store_start, 0);
            if (!pin_drive_low) drv_drop = 1;
            if (rd_ok || wr_ok) grant_bad = 1;
         end
         chk(!drv_drop, "R8 drive held until done", drv_drop, 0);
         store_done = 1;
         tick();
         store_done = 0;
         chk(pin_drive_low == 0, "R8 release after done", pin_drive_low, 0);
         if (!early) begin
            for (int k = 0; k < hold_dly; k++) begin
               if (rd_ok || wr_ok) grant_bad = 1;
               tick();
            end
            ext_low = 0;
         end
         for (int n = 1; n <= res + 1; n++) begin
            tick();
            if (n < res && (rd_ok || wr_ok)) grant_bad = 1;
            if (n == res) chk(wr_ok == 1, "R9 resume latency", wr_ok, 1);
         end
         chk(!grant_bad, "R9 no grant while disabled", grant_bad, 0);
      end else begin
         chk(first_start < 0, "R4 no start without dirty", first_start, -1);
         chk(!drv_early && !pin_drive_low, "R4 pin never driven", pin_drive_low, 0);
         acc_req = 0;
         tick();
         acc_req = 1;
         acc_wr = 1;
         ext_low = 0;
         for (int n = 1; n <= S + 1; n++) begin
            tick();
            if (n == S) chk(wr_ok == 0, "R7 write refused until pin high", wr_ok, 0);
            if (n == S + 1) chk(wr_ok == 1, "R7 write after pin release", wr_ok, 1);
         end
      end
      repeat (3) tick();
   endtask

   initial begin
      int seen;
      void'($urandom(32'd7713));
      repeat (3) tick();
      chk(pin_drive_low == 0, "R1 reset drive released", pin_drive_low, 0);
      chk(store_start == 0, "R1 reset no start", store_start, 0);
      rst_n = 1;
      acc_req = 1;
      acc_wr = 1;
      repeat (3) tick();
      chk(wr_ok == 1, "R1 write granted after reset", wr_ok, 1);

      // R2 short pulse
      dirty = 1;
      acc_wr = 0;
      ext_low = 1;
      repeat (M - 1) tick();
      ext_low = 0;
      seen = 0;
      for (int k = 0; k < 30; k++) begin
         tick();
         if (store_start || pin_drive_low) seen++;
      end
      chk(seen == 0, "R2 short pulse ignored", seen, 0);
      acc_wr = 1;
      tick();
      chk(wr_ok == 1, "R2 write after short pulse", wr_ok, 1);

      // R2 pulse of exact minimum
      acc_wr = 0;
      ext_low = 1;
      repeat (M) tick();
      ext_low = 0;
      store_done = 1;
      seen = 0;
      for (int k = 0; k < 40; k++) begin
         tick();
         if (store_start) seen++;
      end
      store_done = 0;
      chk(seen == 1, "R2 minimum pulse accepted", seen, 1);
      repeat (20) tick();

      // R10 done pulse while idle
      acc_wr = 1;
      store_done = 1;
      tick();
      store_done = 0;
      tick();
      chk(pin_drive_low == 0, "R10 idle done no drive", pin_drive_low, 0);
      chk(wr_ok == 1, "R10 idle done keeps grants", wr_ok, 1);

      // directed stores
      run_store(1, 0, 0, 1, 5, 3);   // R10 done during grace ignored
      run_store(1, 1, 1, 0, 1, 0);
      run_store(0, 1, 0, 0, 1, 0);
      run_store(0, 0, 0, 0, 1, 0);
      run_store(1, 0, 0, 0, 12, 0);

      for (int it = 0; it < 10; it++) begin
         run_store(($urandom % 4) != 0, $urandom % 2, $urandom % 2, $urandom % 2,
                   1 + ($urandom % 20), $urandom % 8);
      end
      summary();
   end

endmodule